// File: doc/BRIEF.md
# Single-Accumulator Processor Core

This block is a small one-address processor. One accumulator is the implicit source and destination of every arithmetic and logic operation, and each instruction names at most one data-memory address. The core has no index register. Pointer-style access uses two indirect loads instead. One takes its pointer from a memory word. The other takes its pointer from the accumulator itself. A matching indirect store writes through a pointer held in memory.

Program memory and data memory are both inside the block. While the core is idle, a test write port loads them. A test read port returns any word of either memory combinationally, so results can be inspected after a run. After reset, a `start` pulse sets the core running. It fetches and executes until it reaches a halt instruction. It then raises `halted` and freezes.

An instruction word is 12 bits wide. Bits [11:8] hold the opcode and bits [7:0] hold the address. Data words are 16 bits wide. When a data word is used as a pointer, only its low 8 bits are used.

Top module: `acc_core`

## Requirements
- R1: After reset, `acc_out` = 0, `pc_out` = 0 and `halted` = 0. The core stays idle, with `pc_out` held at 0, until `start` is sampled high.
- R2: Every instruction starts with one fetch cycle that reads program memory at the program counter and increments it by 1, modulo 256. A direct instruction then takes one execute cycle, for 2 cycles in all. Opcodes 0 and 14 do nothing.
- R3: Opcode 1 (direct load) copies the data word at the address field into the accumulator.
- R4: Opcode 2 (load through memory pointer) reads the data word at the address field. It uses the low 8 bits of that word as a pointer and loads the word at the pointer into the accumulator. This costs one extra cycle, for 3 in all.
- R5: Opcode 3 (load through accumulator) ignores the address field. It uses the low 8 bits of the accumulator as the pointer and replaces the accumulator with the word at the pointer. This takes 3 cycles.
- R6: Opcode 4 (direct store) writes the accumulator to the data word at the address field. Opcode 5 (store through memory pointer) writes it to the word whose address is the low 8 bits of the data word at the address field, in 3 cycles. Neither store changes the accumulator.
- R7: Opcodes 6, 7, 8, 9 and 10 set the accumulator to acc+M, acc−M, acc AND M, acc OR M and acc XOR M, where M is the data word at the address field. Sums and differences wrap modulo 2^16, so load y, add z, store x leaves x = (y+z) mod 65536.
- R8: Opcode 11 always jumps to the address field. Opcode 12 jumps only if the accumulator is zero. Opcode 13 jumps only if accumulator bit 15 is 1. A jump that is not taken falls through to the next instruction.
- R9: Opcode 15 halts the core. From then until reset, `halted` stays 1 and `pc_out` and `acc_out` do not change, even if `start` is pulsed again.
- R10: With `tw_en` high, `tw_sel` = 0 writes the low 12 bits of `tw_data` into program memory at `tw_addr`, and `tw_sel` = 1 writes `tw_data` into data memory. `tr_data` shows the word at `tr_addr` of data memory when `tr_sel` = 1, and of program memory, zero-extended, when `tr_sel` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Leave idle and begin fetching at address 0 |
| tw_en | input | 1 | Test write enable |
| tw_sel | input | 1 | Test write target: 0 program, 1 data memory |
| tw_addr | input | 8 | Test write address |
| tw_data | input | 16 | Test write data (low 12 bits for program memory) |
| tr_sel | input | 1 | Test read source: 0 program, 1 data memory |
| tr_addr | input | 8 | Test read address |
| tr_data | output | 16 | Test read data |
| acc_out | output | 16 | Accumulator |
| pc_out | output | 8 | Program counter |
| halted | output | 1 | Core has executed a halt |

## Verification
The core is run on four programs.

- **Arithmetic program:** a wrapping add, a subtract back below zero, and an AND/OR/XOR chain. These separate the ALU functions from one another and expose any carry handling that does not truncate.
- **Pointer program:** uses both indirect loads and the indirect store. Its pointer word has nonzero upper bits, so a design that uses the wrong pointer source or the wrong pointer width gives a different word. The extra cycle taken by each indirect access separates those accesses from direct ones in the per-cycle trace.
- **Jump program:** a countdown loop, plus conditional jumps tested on zero, negative and positive accumulators. It separates taken jumps from not-taken ones, and a skipped store shows up as a memory word left at its old value.
- **NOP and halt program:** checks that the idle opcodes do nothing and that the halt state holds when `start` is pulsed again.

// File: rtl/acc_pkg.sv
// Package: shared encodings for the single-accumulator core.
// Assumes an instruction word is opcode bits above address bits.
package acc_pkg;
    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_NOP    = 4'd0,
        OP_LOAD   = 4'd1,
        OP_LOADP  = 4'd2,
        OP_LOADA  = 4'd3,
        OP_STORE  = 4'd4,
        OP_STOREP = 4'd5,
        OP_ADD    = 4'd6,
        OP_SUB    = 4'd7,
        OP_AND    = 4'd8,
        OP_OR     = 4'd9,
        OP_XOR    = 4'd10,
        OP_JMP    = 4'd11,
        OP_JZ     = 4'd12,
        OP_JNEG   = 4'd13,
        OP_RSVD   = 4'd14,
        OP_HALT   = 4'd15
    } opcode_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_EXEC  = 3'd2,
        ST_PTR   = 3'd3,
        ST_HALT  = 3'd4
    } state_t;

    // True for instructions that spend a second memory cycle at a pointer.
    function automatic logic uses_pointer(opcode_t op);
        return (op == OP_LOADP) || (op == OP_LOADA) || (op == OP_STOREP);
    endfunction
endpackage

// File: rtl/acc_mem.sv
// Module: word memory with one synchronous write port and two
// asynchronous read ports. Assumes no reset of contents.
module acc_mem #(
    parameter int W  = 16,
    parameter int AW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] words [DEPTH];

    // Write one word on the rising edge when enabled.
    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    // Read both ports combinationally.
    always_comb begin
        rdata_a = words[raddr_a];
        rdata_b = words[raddr_b];
    end
endmodule

// File: rtl/acc_alu.sv
// Module: accumulator combiner. Forms acc <op> operand for the
// arithmetic and logic opcodes. Assumes wraparound arithmetic.
module acc_alu
    import acc_pkg::*;
#(
    parameter int DW = 16
) (
    input  opcode_t       op,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] operand,
    output logic [DW-1:0] result
);
    // Select the operation named by the opcode.
    always_comb begin
        unique case (op)
            OP_ADD:  result = acc + operand;
            OP_SUB:  result = acc - operand;
            OP_AND:  result = acc & operand;
            OP_OR:   result = acc | operand;
            OP_XOR:  result = acc ^ operand;
            default: result = operand;
        endcase
    end
endmodule

// File: rtl/acc_ctrl.sv
// Module: sequencer of the core. Holds accumulator, program counter,
// instruction and pointer registers and steps idle/fetch/execute/
// pointer/halt. Assumes memories read combinationally and DW > AW.
module acc_ctrl
    import acc_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8,
    localparam int IW = OPW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [IW-1:0] instr,
    input  logic [DW-1:0] dm_rdata,
    input  logic [DW-1:0] alu_y,
    output logic [AW-1:0] im_addr,
    output logic [AW-1:0] dm_addr,
    output logic          dm_we,
    output logic [DW-1:0] dm_wdata,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc,
    output state_t        state,
    output opcode_t       ir_op,
    output logic [AW-1:0] ir_addr
);
    state_t        state_q;
    logic [DW-1:0] acc_q;
    logic [AW-1:0] pc_q;
    logic [IW-1:0] ir_q;
    logic [AW-1:0] ptr_q;
    opcode_t       op;

    // Split the held instruction into opcode and address.
    always_comb begin
        op      = opcode_t'(ir_q[IW-1:AW]);
        ir_op   = op;
        ir_addr = ir_q[AW-1:0];
    end

    // Step the state machine and update the architectural registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            acc_q   <= '0;
            pc_q    <= '0;
            ir_q    <= '0;
            ptr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) state_q <= ST_FETCH;
                end
                ST_FETCH: begin
                    ir_q    <= instr;
                    pc_q    <= pc_q + 1'b1;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    state_q <= ST_FETCH;
                    unique case (op)
                        OP_LOAD: acc_q <= dm_rdata;
                        OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: acc_q <= alu_y;
                        OP_LOADP, OP_STOREP: begin
                            ptr_q   <= dm_rdata[AW-1:0];
                            state_q <= ST_PTR;
                        end
                        OP_LOADA: begin
                            ptr_q   <= acc_q[AW-1:0];
                            state_q <= ST_PTR;
                        end
                        OP_JMP:  pc_q <= ir_q[AW-1:0];
                        OP_JZ:   if (acc_q == '0) pc_q <= ir_q[AW-1:0];
                        OP_JNEG: if (acc_q[DW-1]) pc_q <= ir_q[AW-1:0];
                        OP_HALT: state_q <= ST_HALT;
                        default: ;
                    endcase
                end
                ST_PTR: begin
                    if (op != OP_STOREP) acc_q <= dm_rdata;
                    state_q <= ST_FETCH;
                end
                ST_HALT: ;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive memory addresses and the store strobe from the current state.
    always_comb begin
        im_addr  = pc_q;
        dm_addr  = (state_q == ST_PTR) ? ptr_q : ir_q[AW-1:0];
        dm_we    = ((state_q == ST_EXEC) && (op == OP_STORE)) ||
                   ((state_q == ST_PTR) && (op == OP_STOREP));
        dm_wdata = acc_q;
        acc      = acc_q;
        pc       = pc_q;
        state    = state_q;
    end
endmodule

// File: rtl/acc_core.sv
// Module: top of the single-accumulator core. Joins the sequencer, the
// combiner and the two internal memories and exposes a test port to
// preload and inspect them. Assumes test writes are made while idle.
module acc_core
    import acc_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8,
    localparam int IW = OPW + AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tw_en,
    input  logic          tw_sel,
    input  logic [AW-1:0] tw_addr,
    input  logic [DW-1:0] tw_data,
    input  logic          tr_sel,
    input  logic [AW-1:0] tr_addr,
    output logic [DW-1:0] tr_data,
    output logic [DW-1:0] acc_out,
    output logic [AW-1:0] pc_out,
    output logic          halted
);
    logic [AW-1:0] im_addr, dm_addr, ir_addr, dm_waddr;
    logic [IW-1:0] instr, im_test;
    logic [DW-1:0] dm_rdata, dm_wdata, dm_test, alu_y, acc, dm_wmux;
    logic          dm_we, dm_we_any, im_we;
    state_t        state;
    opcode_t       ir_op;

    acc_ctrl #(.DW(DW), .AW(AW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .dm_rdata(dm_rdata), .alu_y(alu_y), .im_addr(im_addr),
        .dm_addr(dm_addr), .dm_we(dm_we), .dm_wdata(dm_wdata),
        .acc(acc), .pc(pc_out), .state(state), .ir_op(ir_op),
        .ir_addr(ir_addr)
    );

    acc_alu #(.DW(DW)) u_alu (
        .op(ir_op), .acc(acc), .operand(dm_rdata), .result(alu_y)
    );

    // Merge core stores and test writes; the core has priority.
    always_comb begin
        im_we     = tw_en && !tw_sel;
        dm_we_any = dm_we || (tw_en && tw_sel);
        dm_waddr  = dm_we ? dm_addr : tw_addr;
        dm_wmux   = dm_we ? dm_wdata : tw_data;
    end

    acc_mem #(.W(IW), .AW(AW)) u_imem (
        .clk(clk), .we(im_we), .waddr(tw_addr), .wdata(tw_data[IW-1:0]),
        .raddr_a(im_addr), .rdata_a(instr),
        .raddr_b(tr_addr), .rdata_b(im_test)
    );

    acc_mem #(.W(DW), .AW(AW)) u_dmem (
        .clk(clk), .we(dm_we_any), .waddr(dm_waddr), .wdata(dm_wmux),
        .raddr_a(dm_addr), .rdata_a(dm_rdata),
        .raddr_b(tr_addr), .rdata_b(dm_test)
    );

    // Present test read data and status.
    always_comb begin
        tr_data = tr_sel ? dm_test : {{(DW-IW){1'b0}}, im_test};
        acc_out = acc;
        halted  = (state == ST_HALT);
    end
endmodule

// File: rtl/acc_core_chk.sv
// Module: property checker for acc_core, attached by bind below.
// Assumes it sees the sequencer state and decoded instruction.
module acc_core_chk
    import acc_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input state_t        state,
    input opcode_t       ir_op,
    input logic [AW-1:0] ir_addr,
    input logic [DW-1:0] acc,
    input logic [AW-1:0] pc,
    input logic          halted
);
    // R1: while idle the core holds its reset values.
    p_idle_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (pc == '0 && acc == '0));

    // R2: each fetch advances the program counter by exactly one.
    p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH) |=> (pc == $past(pc) + 1'b1));

    // R4 / R5: indirect instructions spend one extra cycle at the pointer.
    p_ptr_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && uses_pointer(ir_op)) |=> (state == ST_PTR));

    // R6: a direct store leaves the accumulator unchanged.
    p_store_keeps_acc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir_op == OP_STORE) |=> $stable(acc));

    // R8: a zero accumulator makes the conditional jump land on its target.
    p_jz_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && ir_op == OP_JZ && acc == '0) |=> (pc == $past(ir_addr)));

    // R9: once halted, nothing moves.
    p_halt_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && $stable(pc) && $stable(acc)));
endmodule

bind acc_core acc_core_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .ir_op(ir_op),
    .ir_addr(ir_addr), .acc(acc), .pc(pc_out), .halted(halted)
);

// File: tb/acc_core_test.sv
// Bench: per-cycle behavioural model of the accumulator core compared
// against the design on every clock, plus memory result checks.
module acc_core_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tw_en = 1'b0;
    logic        tw_sel = 1'b0;
    logic [7:0]  tw_addr = '0;
    logic [15:0] tw_data = '0;
    logic        tr_sel = 1'b1;
    logic [7:0]  tr_addr = '0;
    logic [15:0] tr_data;
    logic [15:0] acc_out;
    logic [7:0]  pc_out;
    logic        halted;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    acc_core uut (
        .clk(clk), .rst_n(rst_n), .start(start), .tw_en(tw_en),
        .tw_sel(tw_sel), .tw_addr(tw_addr), .tw_data(tw_data),
        .tr_sel(tr_sel), .tr_addr(tr_addr), .tr_data(tr_data),
        .acc_out(acc_out), .pc_out(pc_out), .halted(halted)
    );

    always #5 clk = ~clk;

    // Reference model state: phase 0 idle, 1 fetch, 2 execute, 3 pointer, 4 halted.
    logic [11:0] m_im [256];
    logic [15:0] m_dm [256];
    int          ph = 0;
    logic [15:0] macc = '0;
    logic [7:0]  mpc = '0, ma = '0, mptr = '0;
    logic [11:0] mir = '0;
    int          mop = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            ph = 0; macc = '0; mpc = '0;
        end else begin
            case (ph)
                0: if (start) ph = 1;
                1: begin mir = m_im[mpc]; mpc = mpc + 8'd1; ph = 2; end
                2: begin
                    mop = int'(mir[11:8]); ma = mir[7:0]; ph = 1;
                    case (mop)
                        1: macc = m_dm[ma];
                        2, 5: begin mptr = m_dm[ma][7:0]; ph = 3; end
                        3: begin mptr = macc[7:0]; ph = 3; end
                        4: m_dm[ma] = macc;
                        6: macc = macc + m_dm[ma];
                        7: macc = macc - m_dm[ma];
                        8: macc = macc & m_dm[ma];
                        9: macc = macc | m_dm[ma];
                        10: macc = macc ^ m_dm[ma];
                        11: mpc = ma;
                        12: if (macc == 16'd0) mpc = ma;
                        13: if (macc[15]) mpc = ma;
                        15: ph = 4;
                        default: ;
                    endcase
                end
                3: begin
                    if (mop == 5) m_dm[mptr] = macc; else macc = m_dm[mptr];
                    ph = 1;
                end
                default: ;
            endcase
        end
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog: cycles %0d expected below 150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic tw(input logic sel, input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        tw_en = 1'b1; tw_sel = sel; tw_addr = a; tw_data = d;
        if (sel) m_dm[a] = d; else m_im[a] = d[11:0];
        @(negedge clk);
        tw_en = 1'b0;
    endtask

    function automatic logic [15:0] ins(input int op, input int a);
        return {4'd0, 4'(op), 8'(a)};
    endfunction

    task automatic peek(input string tag, input logic sel, input logic [7:0] a, input logic [15:0] exp);
        @(negedge clk);
        tr_sel = sel; tr_addr = a;
        #1 chk(tag, "memory word", tr_data, exp);
    endtask

    // Compare the architectural outputs with the model on this cycle.
    task automatic cmp_cycle(input string tag);
        chk(tag, "acc_out", acc_out, macc);
        chk(tag, "pc_out", {8'd0, pc_out}, {8'd0, mpc});
        chk(tag, "halted", {15'd0, halted}, {15'd0, (ph == 4)});
    endtask

    // Reset, start, run to halt comparing every clock, then pulse start while halted (R9).
    task automatic run(input string tag);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1; start = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            start = 1'b0;
            cmp_cycle(tag);
            if (ph == 4) break;
        end
        for (int i = 0; i < 3; i++) begin
            start = 1'b1;
            @(negedge clk);
            cmp_cycle("R9");
        end
        start = 1'b0;
    endtask

    initial begin
        // Clear both memories on design and model alike.
        for (int i = 0; i < 256; i++) begin
            tw(1'b0, 8'(i), 16'd0);
            tw(1'b1, 8'(i), 16'd0);
        end

        // R1: reset values and idling without start.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R1", "idle acc", acc_out, 16'd0);
            chk("R1", "idle pc", {8'd0, pc_out}, 16'd0);
            chk("R1", "idle halted", {15'd0, halted}, 16'd0);
        end

        // R10: test port writes and reads both memories.
        tw(1'b0, 8'd200, 16'hFABC);
        peek("R10", 1'b0, 8'd200, 16'h0ABC);
        tw(1'b1, 8'd200, 16'hFABC);
        peek("R10", 1'b1, 8'd200, 16'hFABC);

        // Program 1: R3 and R7, wrapping add and logic chain.
        tw(1'b1, 8'd10, 16'hFFF0); tw(1'b1, 8'd11, 16'h0025);
        tw(1'b1, 8'd13, 16'h0F0F); tw(1'b1, 8'd14, 16'h00FF);
        tw(1'b0, 8'd0, ins(1, 10)); tw(1'b0, 8'd1, ins(6, 11));
        tw(1'b0, 8'd2, ins(4, 12)); tw(1'b0, 8'd3, ins(7, 11));
        tw(1'b0, 8'd4, ins(4, 15)); tw(1'b0, 8'd5, ins(8, 13));
        tw(1'b0, 8'd6, ins(9, 14)); tw(1'b0, 8'd7, ins(10, 13));
        tw(1'b0, 8'd8, ins(4, 16)); tw(1'b0, 8'd9, ins(15, 0));
        run("R3 R7");
        peek("R7", 1'b1, 8'd12, 16'h0015);
        peek("R7", 1'b1, 8'd15, 16'hFFF0);
        peek("R7", 1'b1, 8'd16, 16'h00F0);

        // Program 2: R4, R5, R6 pointer loads and stores.
        tw(1'b1, 8'd20, 16'd30); tw(1'b1, 8'd30, 16'h1234);
        tw(1'b1, 8'd21, 16'hFF28); tw(1'b1, 8'd40, 16'hBEEF);
        tw(1'b1, 8'd22, 16'h0032);
        tw(1'b0, 8'd0, ins(2, 20)); tw(1'b0, 8'd1, ins(4, 23));
        tw(1'b0, 8'd2, ins(1, 21)); tw(1'b0, 8'd3, ins(3, 0));
        tw(1'b0, 8'd4, ins(5, 22)); tw(1'b0, 8'd5, ins(15, 0));
        run("R4 R5 R6");
        peek("R4", 1'b1, 8'd23, 16'h1234);
        peek("R6", 1'b1, 8'd50, 16'hBEEF);
        chk("R5", "final acc", acc_out, 16'hBEEF);

        // Program 3: R8 loop and conditional jumps taken and not taken.
        tw(1'b1, 8'd0, 16'd3); tw(1'b1, 8'd1, 16'd1);
        tw(1'b1, 8'd3, 16'h8000); tw(1'b1, 8'd4, 16'h5555);
        tw(1'b1, 8'd2, 16'h7777);
        tw(1'b0, 8'd0, ins(1, 0));   tw(1'b0, 8'd1, ins(7, 1));
        tw(1'b0, 8'd2, ins(12, 4));  tw(1'b0, 8'd3, ins(11, 1));
        tw(1'b0, 8'd4, ins(4, 2));   tw(1'b0, 8'd5, ins(1, 3));
        tw(1'b0, 8'd6, ins(12, 9));  tw(1'b0, 8'd7, ins(13, 10));
        tw(1'b0, 8'd8, ins(4, 4));   tw(1'b0, 8'd9, ins(15, 0));
        tw(1'b0, 8'd10, ins(4, 5));  tw(1'b0, 8'd11, ins(1, 0));
        tw(1'b0, 8'd12, ins(13, 8)); tw(1'b0, 8'd13, ins(15, 0));
        run("R8");
        peek("R8", 1'b1, 8'd2, 16'h0000);
        peek("R8", 1'b1, 8'd5, 16'h8000);
        peek("R8", 1'b1, 8'd4, 16'h5555);
        chk("R8", "final pc", {8'd0, pc_out}, 16'd14);

        // Program 4: R2 idle opcodes then R9 halt.
        tw(1'b1, 8'd60, 16'h0042);
        tw(1'b0, 8'd0, ins(0, 60)); tw(1'b0, 8'd1, ins(14, 60));
        tw(1'b0, 8'd2, ins(1, 60)); tw(1'b0, 8'd3, ins(15, 0));
        run("R2 R9");
        chk("R9", "halted acc", acc_out, 16'h0042);
        chk("R9", "halted pc", {8'd0, pc_out}, 16'd4);

        summary();
        $finish;
    end
endmodule